// File: doc/BRIEF.md
# External PID Context Selector

This block keeps two alternate-address-space context registers, one used by external loads and one by external stores. Supervisor code writes each register through a small register-write port. The fields the block does not support are dropped on the way in. Each accepted write raises a one-cycle flush request for the cached translations of that register's own access class, and for no other class.

For every memory access the caller presents a 2-bit access class. The block returns the translation context for that access: a process ID, an address-space bit, a privilege bit, and a flag that says whether an external context is in use. For a normal access the flag is low and the caller searches with its usual PID set. In the same cycle the block also forms the two syndrome bits that a data-storage translation fault reports.

Top module: `epc_selector`

## Requirements
- R1: After reset both context registers read as zero, and neither flush request is asserted.
- R2: A supervisor write stores the written value ANDed with 0xC00000FF. Only PID (bits 7:0), AS (bit 30) and PR (bit 31) are kept; bits 21:16 and bit 29 read back as zero.
- R3: A write while `sup_mode` is low has no effect: no register changes and no flush request is raised.
- R4: A supervisor write with `wr_sel`=0 updates the load register and pulses `flush_ld` for exactly the one cycle after the write cycle, while `flush_st` stays low.
- R5: A supervisor write with `wr_sel`=1 updates the store register and pulses `flush_st` for exactly the one cycle after the write cycle, while `flush_ld` stays low.
- R6: For `acc_class`=01 (external load), `ctx_pid` is load-register bits 7:0, `ctx_as` is bit 30, `ctx_pr` is bit 31, and `ctx_ext` is 1.
- R7: For `acc_class`=10 (external store), the same fields come from the store register, and `ctx_ext` is 1.
- R8: For `acc_class`=00 or 11 (normal), `ctx_as` follows `cur_dr`, `ctx_pr` follows `cur_pr`, `ctx_ext` is 0 and `ctx_pid` is 0.
- R9: `flt_store` equals `acc_write`. `flt_ext` is 1 exactly when `acc_class` is 01 or 10.
- R10: `rd_data` returns the register chosen by `rd_sel` (0 load, 1 store) when `sup_mode` is high, and zero when it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_mode | input | 1 | Processor is in supervisor mode |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 load register, 1 store register |
| wr_data | input | 32 | Write value |
| rd_sel | input | 1 | Read target: 0 load register, 1 store register |
| rd_data | output | 32 | Read value, zero outside supervisor mode |
| acc_class | input | 2 | Access class: 00 normal, 01 external load, 10 external store, 11 normal |
| acc_write | input | 1 | Access is a store |
| cur_dr | input | 1 | Current data-relocate address-space state |
| cur_pr | input | 1 | Current privilege state |
| ctx_pid | output | 8 | Translation process ID |
| ctx_as | output | 1 | Translation address-space bit |
| ctx_pr | output | 1 | Translation privilege bit |
| ctx_ext | output | 1 | External context in use |
| flt_store | output | 1 | Fault syndrome store bit |
| flt_ext | output | 1 | Fault syndrome external-PID bit |
| flush_ld | output | 1 | Flush request for external-load translations |
| flush_st | output | 1 | Flush request for external-store translations |

## Verification
The assertions check on every cycle that a flush request follows an accepted write of its own class one cycle later and never follows anything else. They also check that registers hold when no supervisor write occurs, that masked-off bits never appear on the read port, that normal accesses pass through the current state, and that the syndrome bits track the access. Only the bench's scenarios show the concrete field positions: the exact PID, AS and PR values chosen for each external class from known register contents, the reset values, and the zero read outside supervisor mode.

// File: rtl/epc_pkg.sv
package epc_pkg;

    localparam int DATA_W = 32;
    localparam int PID_W  = 8;

    localparam int PID_LSB = 0;
    localparam int AS_BIT  = 30;
    localparam int PR_BIT  = 31;

    localparam logic [DATA_W-1:0] KEEP_MASK = 32'hC000_00FF;

    localparam int NUM_CLASS = 2;

    typedef enum logic [1:0] {
        ACC_NORMAL = 2'b00,
        ACC_EXT_LD = 2'b01,
        ACC_EXT_ST = 2'b10,
        ACC_RSVD   = 2'b11
    } acc_class_e;

    typedef struct packed {
        logic [PID_W-1:0] pid;
        logic             as_bit;
        logic             pr_bit;
        logic             ext;
    } xlat_ctx_t;

    typedef struct packed {
        logic store;
        logic ext;
    } fault_syn_t;

    function automatic xlat_ctx_t unpack_ctx(input logic [DATA_W-1:0] raw);
        xlat_ctx_t c;
        c.pid    = raw[PID_LSB +: PID_W];
        c.as_bit = raw[AS_BIT];
        c.pr_bit = raw[PR_BIT];
        c.ext    = 1'b1;
        return c;
    endfunction

    function automatic logic is_external(input acc_class_e cls);
        return (cls == ACC_EXT_LD) || (cls == ACC_EXT_ST);
    endfunction

endpackage

// File: rtl/epc_ctx_reg.sv
module epc_ctx_reg
    import epc_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] mask,
    output logic [W-1:0] value,
    output logic         flush
);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
            flush <= 1'b0;
        end else begin
            flush <= we;
            if (we) begin
                value <= wdata & mask;
            end
        end
    end

endmodule

// File: rtl/epc_ctx_mux.sv
module epc_ctx_mux
    import epc_pkg::*;
(
    input  acc_class_e cls,
    input  xlat_ctx_t  ld_ctx,
    input  xlat_ctx_t  st_ctx,
    input  logic       cur_dr,
    input  logic       cur_pr,
    output xlat_ctx_t  ctx
);

    always_comb begin
        unique case (cls)
            ACC_EXT_LD: ctx = ld_ctx;
            ACC_EXT_ST: ctx = st_ctx;
            default: begin
                ctx.pid    = '0;
                ctx.as_bit = cur_dr;
                ctx.pr_bit = cur_pr;
                ctx.ext    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/epc_syndrome.sv
module epc_syndrome
    import epc_pkg::*;
(
    input  acc_class_e cls,
    input  logic       is_write,
    output fault_syn_t syn
);

    always_comb begin
        syn.store = is_write;
        syn.ext   = is_external(cls);
    end

endmodule

// File: rtl/epc_selector.sv
module epc_selector
    import epc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sup_mode,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic [1:0]        acc_class,
    input  logic              acc_write,
    input  logic              cur_dr,
    input  logic              cur_pr,
    output logic [PID_W-1:0]  ctx_pid,
    output logic              ctx_as,
    output logic              ctx_pr,
    output logic              ctx_ext,
    output logic              flt_store,
    output logic              flt_ext,
    output logic              flush_ld,
    output logic              flush_st
);

    logic [DATA_W-1:0] ctx_q   [NUM_CLASS];
    logic              flush_q [NUM_CLASS];
    logic [DATA_W-1:0] ld_q;
    logic [DATA_W-1:0] st_q;

    acc_class_e cls;
    xlat_ctx_t  sel_ctx;
    fault_syn_t syn;

    assign cls = acc_class_e'(acc_class);

    for (genvar g = 0; g < NUM_CLASS; g++) begin : g_ctx
        logic we_g;
        assign we_g = wr_en && sup_mode && (wr_sel == 1'(g));
        epc_ctx_reg #(.W(DATA_W)) u_reg (
            .clk   (clk),
            .rst   (rst),
            .we    (we_g),
            .wdata (wr_data),
            .mask  (KEEP_MASK),
            .value (ctx_q[g]),
            .flush (flush_q[g])
        );
    end

    assign ld_q     = ctx_q[0];
    assign st_q     = ctx_q[1];
    assign flush_ld = flush_q[0];
    assign flush_st = flush_q[1];

    assign rd_data = sup_mode ? (rd_sel ? st_q : ld_q) : '0;

    epc_ctx_mux u_mux (
        .cls    (cls),
        .ld_ctx (unpack_ctx(ld_q)),
        .st_ctx (unpack_ctx(st_q)),
        .cur_dr (cur_dr),
        .cur_pr (cur_pr),
        .ctx    (sel_ctx)
    );

    epc_syndrome u_syn (
        .cls      (cls),
        .is_write (acc_write),
        .syn      (syn)
    );

    assign ctx_pid   = sel_ctx.pid;
    assign ctx_as    = sel_ctx.as_bit;
    assign ctx_pr    = sel_ctx.pr_bit;
    assign ctx_ext   = sel_ctx.ext;
    assign flt_store = syn.store;
    assign flt_ext   = syn.ext;

endmodule

// File: rtl/epc_selector_chk.sv
module epc_selector_chk
    import epc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sup_mode,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [DATA_W-1:0] rd_data,
    input logic [1:0]        acc_class,
    input logic              acc_write,
    input logic              cur_dr,
    input logic              cur_pr,
    input logic [PID_W-1:0]  ctx_pid,
    input logic              ctx_as,
    input logic              ctx_pr,
    input logic              ctx_ext,
    input logic              flt_store,
    input logic              flt_ext,
    input logic              flush_ld,
    input logic              flush_st,
    input logic [DATA_W-1:0] ld_q,
    input logic [DATA_W-1:0] st_q
);

    p_ld_flush_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sup_mode && !wr_sel) |=> (flush_ld && !flush_st));

    p_st_flush_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sup_mode && wr_sel) |=> (flush_st && !flush_ld));

    p_no_spurious_flush_r3: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && sup_mode) |=> (!flush_ld && !flush_st));

    p_hold_regs_r3: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && sup_mode) |=> ($stable(ld_q) && $stable(st_q)));

    p_masked_bits_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~KEEP_MASK) == '0);

    p_normal_ctx_r8: assert property (@(posedge clk) disable iff (rst)
        (acc_class == 2'b00 || acc_class == 2'b11) |->
        (!ctx_ext && ctx_as == cur_dr && ctx_pr == cur_pr && ctx_pid == '0));

    p_syn_store_r9: assert property (@(posedge clk) disable iff (rst)
        flt_store == acc_write);

    p_syn_ext_r9: assert property (@(posedge clk) disable iff (rst)
        flt_ext == ctx_ext);

    p_rd_gate_r10: assert property (@(posedge clk) disable iff (rst)
        !sup_mode |-> rd_data == '0);

endmodule

bind epc_selector epc_selector_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sup_mode  (sup_mode),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .rd_data   (rd_data),
    .acc_class (acc_class),
    .acc_write (acc_write),
    .cur_dr    (cur_dr),
    .cur_pr    (cur_pr),
    .ctx_pid   (ctx_pid),
    .ctx_as    (ctx_as),
    .ctx_pr    (ctx_pr),
    .ctx_ext   (ctx_ext),
    .flt_store (flt_store),
    .flt_ext   (flt_ext),
    .flush_ld  (flush_ld),
    .flush_st  (flush_st),
    .ld_q      (ld_q),
    .st_q      (st_q)
);

// File: tb/test_epc_selector.sv
`timescale 1ns/1ps
module test_epc_selector;

    logic        clk = 1'b0;
    logic        rst;
    logic        sup_mode, wr_en, wr_sel, rd_sel;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic [1:0]  acc_class;
    logic        acc_write, cur_dr, cur_pr;
    logic [7:0]  ctx_pid;
    logic        ctx_as, ctx_pr, ctx_ext;
    logic        flt_store, flt_ext, flush_ld, flush_st;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    epc_selector i_epc_selector (
        .clk(clk), .rst(rst), .sup_mode(sup_mode), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .acc_class(acc_class), .acc_write(acc_write), .cur_dr(cur_dr),
        .cur_pr(cur_pr), .ctx_pid(ctx_pid), .ctx_as(ctx_as), .ctx_pr(ctx_pr),
        .ctx_ext(ctx_ext), .flt_store(flt_store), .flt_ext(flt_ext),
        .flush_ld(flush_ld), .flush_st(flush_st)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic read_reg(input logic sel, output logic [31:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    // Write strobe during one cycle; returns at the negedge after the edge.
    task automatic do_write(input logic sel, input logic [31:0] d, input logic sup);
        @(negedge clk);
        sup_mode = sup; wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; sup_mode = 1'b1;
        #1;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        read_reg(1'b0, v); chk("R1 load reg after reset", v, 32'h0);
        read_reg(1'b1, v); chk("R1 store reg after reset", v, 32'h0);
        chk("R1 flush after reset", {30'b0, flush_ld, flush_st}, 32'h0);
    endtask

    task automatic t_load_write;
        logic [31:0] v;
        do_write(1'b0, 32'hFFFF_FFFF, 1'b1);
        chk("R4 flush pulse after load write", {30'b0, flush_ld, flush_st}, 32'h2);
        read_reg(1'b0, v); chk("R2 load reg masked", v, 32'hC000_00FF);
        @(negedge clk); #1;
        chk("R4 flush ends after one cycle", {30'b0, flush_ld, flush_st}, 32'h0);
    endtask

    task automatic t_store_write;
        logic [31:0] v;
        do_write(1'b1, 32'h7F3F_0012, 1'b1);
        chk("R5 flush pulse after store write", {30'b0, flush_ld, flush_st}, 32'h1);
        read_reg(1'b1, v); chk("R2 store reg drops partition and guest bits", v, 32'h4000_0012);
        @(negedge clk); #1;
        chk("R5 flush ends after one cycle", {30'b0, flush_ld, flush_st}, 32'h0);
    endtask

    task automatic t_ext_ctx;
        @(negedge clk);
        acc_class = 2'b01; cur_dr = 1'b0; cur_pr = 1'b0; #1;
        chk("R6 external load context", {21'b0, ctx_pid, ctx_as, ctx_pr, ctx_ext}, {21'b0, 8'hFF, 3'b111});
        acc_class = 2'b10; #1;
        chk("R7 external store context", {21'b0, ctx_pid, ctx_as, ctx_pr, ctx_ext}, {21'b0, 8'h12, 3'b101});
    endtask

    task automatic t_normal_ctx;
        acc_class = 2'b00; cur_dr = 1'b1; cur_pr = 1'b0; #1;
        chk("R8 normal class 00", {21'b0, ctx_pid, ctx_as, ctx_pr, ctx_ext}, {21'b0, 8'h00, 3'b100});
        acc_class = 2'b11; cur_dr = 1'b0; cur_pr = 1'b1; #1;
        chk("R8 class 11 treated as normal", {21'b0, ctx_pid, ctx_as, ctx_pr, ctx_ext}, {21'b0, 8'h00, 3'b010});
    endtask

    task automatic t_syndrome;
        acc_class = 2'b10; acc_write = 1'b1; #1;
        chk("R9 syndrome external store write", {30'b0, flt_store, flt_ext}, 32'h3);
        acc_class = 2'b01; acc_write = 1'b0; #1;
        chk("R9 syndrome external load read", {30'b0, flt_store, flt_ext}, 32'h1);
        acc_class = 2'b00; acc_write = 1'b1; #1;
        chk("R9 syndrome normal write", {30'b0, flt_store, flt_ext}, 32'h2);
        acc_class = 2'b11; acc_write = 1'b0; #1;
        chk("R9 syndrome class 11 read", {30'b0, flt_store, flt_ext}, 32'h0);
    endtask

    task automatic t_user_write;
        logic [31:0] v;
        do_write(1'b1, 32'h0000_00AA, 1'b0);
        chk("R3 no flush on user write", {30'b0, flush_ld, flush_st}, 32'h0);
        read_reg(1'b1, v); chk("R3 store reg unchanged", v, 32'h4000_0012);
        do_write(1'b0, 32'h0000_0055, 1'b0);
        read_reg(1'b0, v); chk("R3 load reg unchanged", v, 32'hC000_00FF);
    endtask

    task automatic t_read_gate;
        sup_mode = 1'b0; rd_sel = 1'b0; #1;
        chk("R10 read outside supervisor is zero", rd_data, 32'h0);
        sup_mode = 1'b1; #1;
        chk("R10 supervisor read of load reg", rd_data, 32'hC000_00FF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; sup_mode = 1'b1; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
        rd_sel = 1'b0; acc_class = 2'b00; acc_write = 1'b0; cur_dr = 1'b0; cur_pr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset;
        t_load_write;
        t_store_write;
        t_ext_ctx;
        t_normal_ctx;
        t_syndrome;
        t_user_write;
        t_read_gate;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule